// File: doc/BRIEF.md
# Serial Expansion Channel Controller

This block is a single channel of a memory-mapped serial expansion port for plug-in devices. Software programs it through five 32-bit words on a simple register bus. A parameter/status word holds the shift-clock rate, the device select and two interrupt sources with their masks. A control word launches transfers. An immediate data word supplies the bytes to send and returns the bytes received.

An immediate transfer moves 1 to 4 bytes in both directions at once, most significant byte first. The received bits take the place of the sent bits in the data word, and the block raises a transfer-complete status when it finishes. A DMA address word and a DMA length word are stored with 32-byte alignment and passed to a separate DMA engine. A start with the DMA flag set hands the transfer to that engine and waits for its finish pulse. A synchronised device-present input is readable, and any change on it raises an insertion status.

The shift clock is derived from the block clock by a power-of-two divider. When the block clock runs at twice the fastest shift rate, the eight rate codes give the halving ladder from the fastest rate down to 1/64 of it.

Top module: `sx_channel`

## Requirements
- R1: Word offsets: 0x00 status, 0x04 DMA address, 0x08 DMA length, 0x0C control, 0x10 data. The DMA address and DMA length words always read with bits 4:0 as zero, and outputs `dma_base`/`dma_bytes` carry the same values.
- R2: Status word layout: bit0 insertion mask, bit1 insertion status, bit2 done mask, bit3 done status, bits 6:4 rate code, bits 9:7 select, bit10 device present (read only). The select field drives `cs` directly. A status write whose select field has more than one bit set leaves the select unchanged.
- R3: The rate code c sets the `sclk` period to 2·2^(6−c) block clocks for c = 0..6. Code 7 behaves like code 0 (128 clocks).
- R4: Control word layout: bit0 start, bit1 DMA flag, bits 3:2 direction, bits 5:4 length code n. An immediate transfer moves n+1 bytes, giving 8(n+1) rising `sclk` edges. Bits are sent from data bit 31 downward. The received bits replace the top 8(n+1) bits of the data word, and the lower bits are kept.
- R5: Every immediate transfer shifts out and in, whatever the direction code. The direction code is stored and read back.
- R6: The start bit reads 1 while a transfer runs. It clears on the same clock edge that sets the done status.
- R7: Done status is set at the end of every transfer. Writing 1 to bit3 clears it and writing 0 leaves it. If a clear and a set fall on the same edge, the set wins.
- R8: `dev_present` passes two synchronising flops and appears at bit10. Any change of the synchronised level sets the insertion status. Writing 1 to bit1 clears it, and a set on the same edge wins.
- R9: `irq` is the OR of (insertion status AND its mask) and (done status AND its mask). A clear mask never stops its status from being set.
- R10: While the start bit reads 1, writes to the control word, the rate field, the select field and the data word are ignored.
- R11: A start with the DMA flag set raises `dma_run` and produces no `sclk` edges. A `dma_finish` pulse ends it like an immediate transfer: start clears and done status sets.
- R12: `sclk` idles low. `sdo` changes only on falling `sclk` edges, and `sdi` is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the fastest shift rate |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Masked interrupt request |
| sclk | output | 1 | Serial shift clock |
| sdo | output | 1 | Serial data to the device |
| sdi | input | 1 | Serial data from the device |
| cs | output | 3 | One-hot device selects, active high |
| dev_present | input | 1 | Asynchronous device-attached level |
| dma_run | output | 1 | DMA transfer handed to the DMA engine |
| dma_base | output | 32 | Aligned DMA start address |
| dma_bytes | output | 32 | Aligned DMA byte count |
| dma_finish | input | 1 | One-cycle pulse from the DMA engine ending its transfer |

## Verification
The two collisions that matter are a software write-one-to-clear landing on the same edge as a hardware set. One is the clear of the done status on the edge where a transfer ends. The other is the clear of the insertion status on the edge where a synchronised `dev_present` change is detected. The bench provokes the first by counting rising `sclk` edges at the fastest rate and issuing the clear on the clock after the eighth rise of a one-byte transfer. It provokes the second by issuing the clear exactly two clocks after toggling `dev_present`. In both cases the status must read 1 afterwards, and a plain clear at a quiet moment must read 0.

// File: rtl/sx_pkg.sv
package sx_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int SEL_N     = 3;
    localparam int RATE_W    = 3;
    localparam int SLOW_LOG  = 6;                      // log2 of the largest half-period
    localparam int DIV_W     = SLOW_LOG + 1;
    localparam int BITCNT_W  = $clog2(WORD_W) + 1;
    localparam int ALIGN_LOG = 5;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_BASE  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_BYTES = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h10;

    // status word, bit 10 down to bit 0
    typedef struct packed {
        logic              present;
        logic [SEL_N-1:0]  sel;
        logic [RATE_W-1:0] rate;
        logic              done_st;
        logic              done_en;
        logic              ins_st;
        logic              ins_en;
    } stat_t;
    localparam int STAT_W = $bits(stat_t);

    // control word, bit 5 down to bit 0
    typedef struct packed {
        logic [1:0] nlen;
        logic [1:0] dir;
        logic       dma;
        logic       start;
    } ctrl_t;
    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

    // log2 of the half-period in block clocks; the top code aliases the slowest
    function automatic logic [2:0] rate_log(input logic [RATE_W-1:0] code);
        if (code == '1) return 3'(SLOW_LOG);
        return 3'(SLOW_LOG) - code;
    endfunction

    // place received bits in the top bytes, keep the untouched low bytes
    function automatic logic [WORD_W-1:0] merge_rx(input logic [WORD_W-1:0] rx,
                                                   input logic [WORD_W-1:0] old,
                                                   input logic [1:0]        nlen);
        int unsigned       keep;
        logic [WORD_W-1:0] lowmask;
        keep    = WORD_W - 8 * (int'(nlen) + 1);
        lowmask = (WORD_W'(1) << keep) - WORD_W'(1);
        return (rx << keep) | (old & lowmask);
    endfunction

endpackage

// File: rtl/sx_rate_div.sv
module sx_rate_div
    import sx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    assign limit = DIV_W'(1) << rate_log(rate);
    assign tick  = run && (cnt_q == limit - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/sx_shifter.sv
module sx_shifter
    import sx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [1:0]        nlen,
    input  logic [WORD_W-1:0] load,
    input  logic              tick,
    input  logic              sdi,
    output logic              busy,
    output logic              sclk,
    output logic              sdo,
    output logic              fin,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0]   tx_q;
    logic [WORD_W-1:0]   rx_q;
    logic                samp_q;
    logic [BITCNT_W-1:0] left_q;
    phase_e              ph_q;
    logic                busy_q;

    assign busy    = busy_q;
    assign sclk    = (ph_q == PH_HIGH);
    assign sdo     = tx_q[WORD_W-1];
    assign rx_word = {rx_q[WORD_W-2:0], samp_q};
    assign fin     = busy_q && tick && (ph_q == PH_HIGH) && (left_q == BITCNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            samp_q <= 1'b0;
            left_q <= '0;
            ph_q   <= PH_LOW;
            busy_q <= 1'b0;
        end else if (go && !busy_q) begin
            busy_q <= 1'b1;
            ph_q   <= PH_LOW;
            tx_q   <= load;
            rx_q   <= '0;
            left_q <= BITCNT_W'(8 * (int'(nlen) + 1));
        end else if (busy_q && tick) begin
            if (ph_q == PH_LOW) begin
                ph_q   <= PH_HIGH;
                samp_q <= sdi;
            end else begin
                ph_q   <= PH_LOW;
                tx_q   <= tx_q << 1;
                rx_q   <= rx_word;
                left_q <= left_q - BITCNT_W'(1);
                if (left_q == BITCNT_W'(1)) busy_q <= 1'b0;
            end
        end
    end

    p_idle_low_r12: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (ph_q == PH_LOW));

    p_sdo_on_fall_r12: assert property (@(posedge clk) disable iff (rst)
        (busy_q && ph_q == PH_LOW && tick) |=> $stable(sdo));

    p_fin_ends_r6: assert property (@(posedge clk) disable iff (rst)
        fin |=> !busy_q);

endmodule

// File: rtl/sx_presence.sv
module sx_presence (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic present,
    output logic changed
);

    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign present = s2_q;
    assign changed = s2_q ^ s3_q;

endmodule

// File: rtl/sx_channel.sv
module sx_channel
    import sx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 irq,
    output logic                 sclk,
    output logic                 sdo,
    input  logic                 sdi,
    output logic [SEL_N-1:0]     cs,
    input  logic                 dev_present,
    output logic                 dma_run,
    output logic [WORD_W-1:0]    dma_base,
    output logic [WORD_W-1:0]    dma_bytes,
    input  logic                 dma_finish
);

    stat_t             stat_q;
    ctrl_t             ctrl_q;      // ctrl_q.start doubles as the DMA-active flag
    ctrl_t             rd_ctrl;
    stat_t             wstat;
    ctrl_t             wctrl;
    logic [WORD_W-1:0] data_q, base_q, bytes_q;

    logic wr_stat, wr_base, wr_bytes, wr_ctrl, wr_data;
    logic busy_imm, running, go_imm, fin, tick, done_set;
    logic present_s, ins_chg;
    logic [WORD_W-1:0] rx_word;

    assign wstat    = stat_t'(bus_wdata[STAT_W-1:0]);
    assign wctrl    = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign wr_stat  = bus_we && (bus_addr == OFS_STAT);
    assign wr_base  = bus_we && (bus_addr == OFS_BASE);
    assign wr_bytes = bus_we && (bus_addr == OFS_BYTES);
    assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
    assign wr_data  = bus_we && (bus_addr == OFS_DATA);

    assign running  = busy_imm || ctrl_q.start;
    assign go_imm   = wr_ctrl && !running && wctrl.start && !wctrl.dma;
    assign done_set = fin || (ctrl_q.start && dma_finish);

    sx_rate_div u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_imm),
        .rate (stat_q.rate),
        .tick (tick)
    );

    sx_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go_imm),
        .nlen    (wctrl.nlen),
        .load    (data_q),
        .tick    (tick),
        .sdi     (sdi),
        .busy    (busy_imm),
        .sclk    (sclk),
        .sdo     (sdo),
        .fin     (fin),
        .rx_word (rx_word)
    );

    sx_presence u_pres (
        .clk     (clk),
        .rst     (rst),
        .pin     (dev_present),
        .present (present_s),
        .changed (ins_chg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            ctrl_q  <= '0;
            data_q  <= '0;
            base_q  <= '0;
            bytes_q <= '0;
        end else begin
            stat_q.present <= present_s;

            if (wr_stat) begin
                stat_q.ins_en  <= wstat.ins_en;
                stat_q.done_en <= wstat.done_en;
                if (!running) begin
                    stat_q.rate <= wstat.rate;
                    if ($countones(wstat.sel) <= 1) stat_q.sel <= wstat.sel;
                end
            end

            if (ins_chg)                      stat_q.ins_st <= 1'b1;
            else if (wr_stat && wstat.ins_st) stat_q.ins_st <= 1'b0;

            if (done_set)                      stat_q.done_st <= 1'b1;
            else if (wr_stat && wstat.done_st) stat_q.done_st <= 1'b0;

            if (wr_ctrl && !running) begin
                ctrl_q.nlen  <= wctrl.nlen;
                ctrl_q.dir   <= wctrl.dir;
                ctrl_q.dma   <= wctrl.dma;
                ctrl_q.start <= wctrl.start && wctrl.dma;
            end else if (ctrl_q.start && dma_finish) begin
                ctrl_q.start <= 1'b0;
            end

            if (wr_data && !running) data_q <= bus_wdata;
            else if (fin)            data_q <= merge_rx(rx_word, data_q, ctrl_q.nlen);

            if (wr_base)  base_q  <= {bus_wdata[WORD_W-1:ALIGN_LOG], {ALIGN_LOG{1'b0}}};
            if (wr_bytes) bytes_q <= {bus_wdata[WORD_W-1:ALIGN_LOG], {ALIGN_LOG{1'b0}}};
        end
    end

    always_comb begin
        rd_ctrl       = ctrl_q;
        rd_ctrl.start = running;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STAT:  bus_rdata = WORD_W'(stat_q);
            OFS_BASE:  bus_rdata = base_q;
            OFS_BYTES: bus_rdata = bytes_q;
            OFS_CTRL:  bus_rdata = WORD_W'(rd_ctrl);
            OFS_DATA:  bus_rdata = data_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq       = (stat_q.ins_st && stat_q.ins_en) || (stat_q.done_st && stat_q.done_en);
    assign cs        = stat_q.sel;
    assign dma_run   = ctrl_q.start;
    assign dma_base  = base_q;
    assign dma_bytes = bytes_q;

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs));

    p_sel_hold_r10: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(stat_q.sel));

    p_rate_hold_r10: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(stat_q.rate));

    p_done_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> stat_q.done_st);

    p_ins_set_r8: assert property (@(posedge clk) disable iff (rst)
        ins_chg |=> stat_q.ins_st);

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!stat_q.ins_st && !stat_q.done_st) |-> !irq);

    p_dma_noclk_r11: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.start |-> !sclk);

endmodule

// File: tb/sx_channel_tb.sv
module sx_channel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq, sclk, sdo, sdi;
    logic [2:0]  cs;
    logic        dev_present;
    logic        dma_run, dma_finish;
    logic [31:0] dma_base, dma_bytes;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    sx_channel u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs(cs),
        .dev_present(dev_present), .dma_run(dma_run), .dma_base(dma_base),
        .dma_bytes(dma_bytes), .dma_finish(dma_finish)
    );

    // device model: mode-0 full-duplex shift register
    logic [31:0] dev_sh;
    logic [31:0] host_sh;
    int          nrise;
    time         t_last;
    time         per_ns;

    assign sdi = dev_sh[31];

    always @(negedge sclk) dev_sh <= dev_sh << 1;

    always @(posedge sclk) begin
        host_sh = {host_sh[30:0], sdo};
        if (nrise == 1) per_ns = $time - t_last;
        t_last = $time;
        nrise  = nrise + 1;
    end

    typedef struct packed {
        logic [2:0]  rate;
        logic [1:0]  nlen;
        logic [1:0]  dir;
        logic [31:0] tx;
        logic [31:0] dev;
        logic [31:0] exp;
        logic [7:0]  per;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{3'd6, 2'd0, 2'b01, 32'hA5123456, 32'h3C000000, 32'h3C123456, 8'd2},
        '{3'd5, 2'd1, 2'b00, 32'h1234ABCD, 32'hBEEF0000, 32'hBEEFABCD, 8'd4},
        '{3'd4, 2'd2, 2'b10, 32'hCAFEF00D, 32'h010203FF, 32'h0102030D, 8'd8},
        '{3'd6, 2'd3, 2'b11, 32'hDEADBEEF, 32'h5A5AC3C3, 32'h5A5AC3C3, 8'd2},
        '{3'd7, 2'd0, 2'b01, 32'h80000001, 32'h7F000000, 32'h7F000001, 8'd128},
        '{3'd0, 2'd0, 2'b00, 32'h00FF00FF, 32'hFF000000, 32'hFFFF00FF, 8'd128}
    };

    function automatic logic [31:0] mkstat(logic ins_en, logic ins_clr, logic done_en,
                                           logic done_clr, logic [2:0] rate, logic [2:0] sel);
        return {21'b0, 1'b0, sel, rate, done_clr, done_en, ins_clr, ins_en};
    endfunction

    function automatic logic [31:0] mkctrl(logic [1:0] nlen, logic [1:0] dir,
                                           logic dma, logic start);
        return {26'b0, nlen, dir, dma, start};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a falling clock edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(5'h0C, v);
            if (v[0] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] hmask;
        int          nb;

        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        dev_present = 1'b0; dma_finish = 1'b0;
        dev_sh = '0; host_sh = '0; nrise = 0; t_last = 0; per_ns = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(5'h00, v); chk("R2 reset status", v, 32'h0);
        rd(5'h0C, v); chk("R6 reset control", v, 32'h0);
        chk("R12 reset sclk", {31'b0, sclk}, 32'h0);
        chk("R9 reset irq", {31'b0, irq}, 32'h0);
        chk("R2 reset cs", {29'b0, cs}, 32'h0);

        // R1 alignment of DMA words
        wr(5'h04, 32'hFFFFFFFF);
        rd(5'h04, v); chk("R1 address read", v, 32'hFFFFFFE0);
        chk("R1 address port", dma_base, 32'hFFFFFFE0);
        wr(5'h08, 32'h0000123F);
        rd(5'h08, v); chk("R1 length read", v, 32'h00001220);
        chk("R1 length port", dma_bytes, 32'h00001220);

        // R2 select one-hot
        wr(5'h00, mkstat(0, 0, 0, 0, 3'd6, 3'b010));
        chk("R2 cs follows", {29'b0, cs}, 32'h2);
        wr(5'h00, mkstat(0, 0, 0, 0, 3'd6, 3'b011));
        chk("R2 two-hot rejected", {29'b0, cs}, 32'h2);
        rd(5'h00, v); chk("R2 select field", {29'b0, v[9:7]}, 32'h2);

        // vector table: R3 R4 R5 R6 R7 R12
        for (int k = 0; k < NV; k++) begin
            wr(5'h00, mkstat(0, 0, 0, 1, VEC[k].rate, 3'b001));
            wr(5'h10, VEC[k].tx);
            dev_sh = VEC[k].dev; host_sh = '0; nrise = 0; per_ns = 0;
            wr(5'h0C, mkctrl(VEC[k].nlen, VEC[k].dir, 1'b0, 1'b1));
            wait_idle();
            nb = 8 * (int'(VEC[k].nlen) + 1);
            rd(5'h10, v); chk("R4 data merge", v, VEC[k].exp);
            hmask = (nb == 32) ? 32'hFFFFFFFF : ((32'h1 << nb) - 1);
            chk("R5 device received", host_sh & hmask, VEC[k].tx >> (32 - nb));
            chk("R4 edge count", 32'(nrise), 32'(nb));
            chk("R3 sclk period", 32'(per_ns / 20), 32'(VEC[k].per));
            rd(5'h00, v); chk("R7 done set", {31'b0, v[3]}, 32'h1);
            rd(5'h0C, v); chk("R5 direction kept", {30'b0, v[3:2]}, {30'b0, VEC[k].dir});
            chk("R12 sclk idle after", {31'b0, sclk}, 32'h0);
        end

        // R9 mask gates only irq
        chk("R9 masked irq low", {31'b0, irq}, 32'h0);
        wr(5'h00, mkstat(0, 0, 1, 0, 3'd6, 3'b001));
        chk("R9 unmasked irq", {31'b0, irq}, 32'h1);
        wr(5'h00, mkstat(0, 0, 1, 1, 3'd6, 3'b001));
        rd(5'h00, v); chk("R7 w1c clears", {31'b0, v[3]}, 32'h0);
        chk("R9 irq drops", {31'b0, irq}, 32'h0);

        // R10 writes ignored while running
        wr(5'h00, mkstat(0, 0, 0, 1, 3'd0, 3'b001));
        wr(5'h10, 32'h11223344);
        dev_sh = 32'hA1B2C3D4; nrise = 0;
        wr(5'h0C, mkctrl(2'd3, 2'b01, 1'b0, 1'b1));
        repeat (10) @(negedge clk);
        wr(5'h0C, mkctrl(2'd0, 2'b10, 1'b0, 1'b1));
        wr(5'h00, mkstat(0, 0, 0, 0, 3'd6, 3'b100));
        wr(5'h10, 32'h0);
        chk("R10 cs held", {29'b0, cs}, 32'h1);
        wait_idle();
        rd(5'h10, v); chk("R10 data write ignored", v, 32'hA1B2C3D4);
        rd(5'h0C, v); chk("R10 control ignored", {26'b0, v[5:0]}, 32'h34);
        rd(5'h00, v); chk("R10 rate ignored", {29'b0, v[6:4]}, 32'h0);
        chk("R10 select ignored", {29'b0, v[9:7]}, 32'h1);

        // R7 set wins over clear at transfer end
        wr(5'h00, mkstat(0, 0, 0, 1, 3'd6, 3'b001));
        dev_sh = 32'h0; nrise = 0;
        wr(5'h0C, mkctrl(2'd0, 2'b01, 1'b0, 1'b1));
        wait (nrise == 8);
        @(negedge clk);
        wr(5'h00, mkstat(0, 0, 0, 1, 3'd6, 3'b001));
        rd(5'h00, v); chk("R7 set wins", {31'b0, v[3]}, 32'h1);
        rd(5'h0C, v); chk("R6 start cleared", {31'b0, v[0]}, 32'h0);
        wr(5'h00, mkstat(0, 0, 0, 1, 3'd6, 3'b001));

        // R8 insertion
        dev_present = 1'b1;
        repeat (4) @(negedge clk);
        rd(5'h00, v);
        chk("R8 present bit", {31'b0, v[10]}, 32'h1);
        chk("R8 insertion set", {31'b0, v[1]}, 32'h1);
        chk("R9 ins masked irq", {31'b0, irq}, 32'h0);
        wr(5'h00, mkstat(1, 0, 0, 0, 3'd6, 3'b001));
        chk("R9 ins irq", {31'b0, irq}, 32'h1);
        wr(5'h00, mkstat(1, 1, 0, 0, 3'd6, 3'b001));
        rd(5'h00, v); chk("R8 w1c clears", {31'b0, v[1]}, 32'h0);
        dev_present = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr(5'h00, mkstat(0, 1, 0, 0, 3'd6, 3'b001));
        rd(5'h00, v); chk("R8 set wins", {31'b0, v[1]}, 32'h1);
        repeat (2) @(negedge clk);
        rd(5'h00, v); chk("R8 removal seen", {31'b0, v[10]}, 32'h0);
        wr(5'h00, mkstat(0, 1, 0, 1, 3'd6, 3'b001));

        // R11 DMA hand-off
        nrise = 0;
        wr(5'h0C, mkctrl(2'd0, 2'b01, 1'b1, 1'b1));
        chk("R11 dma_run high", {31'b0, dma_run}, 32'h1);
        rd(5'h0C, v); chk("R11 start reads 1", {31'b0, v[0]}, 32'h1);
        repeat (20) @(negedge clk);
        chk("R11 no sclk edges", 32'(nrise), 32'h0);
        dma_finish = 1'b1;
        @(negedge clk);
        dma_finish = 1'b0;
        chk("R11 dma_run low", {31'b0, dma_run}, 32'h0);
        rd(5'h0C, v); chk("R11 start cleared", {31'b0, v[0]}, 32'h0);
        rd(5'h00, v); chk("R11 done set", {31'b0, v[3]}, 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule